// File: doc/BRIEF.md
# Tributary Frame-Alignment Resync Controller

This block watches four active-high frame-position pulses, one from each 622 Mb/s tributary controller that feeds a four-way byte-interleaving multiplexer. Each pulse is high for exactly one cycle of the tributary clock, on the first payload byte that follows the row-one overhead. The block decides from these pulses whether the four tributaries are frame-aligned. The multiplexer holds no buffer, so the tributaries must already line up when they arrive.

When all four pulses arrive on the same cycle, the block waits for the next coincident frame boundary and then raises a data-valid indication. One frame later it raises a parity-valid indication, which tells the datapath that the parity bytes it computes can now be trusted. A pulse that arrives without its three partners is a misalignment. In that case the block drops both indications and drives an active-low resync reset to the upstream controllers. For the same time it raises a request to stop the tributary clocks. The reset is held for a fixed number of cycles, after which the block returns to searching for a coincident pulse.

Top module: `trib_align_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, the outputs are `resync_n_o`=1, `clk_stop_o`=0, `data_valid_o`=0 and `parity_valid_o`=0, and the block is searching.
- R2: While the block is searching, a cycle on which `fp_i` is all ones moves it to a waiting state. Neither valid output rises on that move.
- R3: While the block is waiting, the next all-ones `fp_i` cycle sets `data_valid_o` high from the following cycle. `parity_valid_o` stays low.
- R4: When `data_valid_o` is high, the next all-ones `fp_i` cycle sets `parity_valid_o` high from the following cycle. Later all-ones cycles keep both valid outputs high.
- R5: While the block is searching, a cycle on which `fp_i` is nonzero but not all ones starts a resync from the following cycle.
- R6: During a resync, `resync_n_o` is low and `clk_stop_o` is high for exactly `RST_CYCLES` consecutive cycles (default 16). After that the block is searching again.
- R7: The values on `fp_i` have no effect during a resync, including all-ones cycles. Its length and the state after it do not change.
- R8: When the block is waiting or either valid output is high, a cycle on which `fp_i` is nonzero but not all ones starts a resync from the following cycle. Both valid outputs drop in that same cycle.
- R9: After a resync ends, valid data is reached again only through the full sequence: one all-ones cycle to leave searching, then a second one.
- R10: `parity_valid_o` is never high while `data_valid_o` is low. Neither valid output is high while `resync_n_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tributary-rate clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fp_i | input | N_TRIB | Frame-position pulse from each tributary, active high |
| resync_n_o | output | 1 | Active-low resync reset to the tributary controllers |
| clk_stop_o | output | 1 | Request to stop the tributary clocks during resync |
| data_valid_o | output | 1 | Output data may be trusted |
| parity_valid_o | output | 1 | Output parity bytes may be trusted |

## Verification
The bench checks the exact length of the resync window. A design that is off by one would hold the reset for 15 or 17 cycles, and a design that re-armed on pulses would stretch it further. It drives coincident pulses in the middle of a resync, which a design that leaks inputs into that state would act on. It also drives lone pulses in every one of the searching, waiting, data-valid and parity-valid states. A design that checked only some of these states would stay valid there, or would start the timer late. After a resync the bench sends a single coincident pulse to catch a design that keeps its old progress and raises data-valid too early.

// File: rtl/trib_align_ctrl.sv
module trib_align_ctrl #(
  parameter int unsigned N_TRIB     = 4,
  parameter int unsigned RST_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_TRIB-1:0] fp_i,
  output logic              resync_n_o,
  output logic              clk_stop_o,
  output logic              data_valid_o,
  output logic              parity_valid_o
);

  localparam int unsigned CW = $clog2(RST_CYCLES + 1);

  typedef enum logic [2:0] {SEARCH, RESYNC, WAIT_DATA, DATA_OK, PARITY_OK} st_t;

  st_t          st, st_nx;
  logic [CW-1:0] cnt, cnt_nx;

  wire all_hit = &fp_i;
  wire partial = (|fp_i) & ~all_hit;

  always_comb begin
    st_nx  = st;
    cnt_nx = cnt;
    case (st)
      SEARCH: begin
        if (all_hit) st_nx = WAIT_DATA;
        else if (partial) begin
          st_nx  = RESYNC;
          cnt_nx = CW'(RST_CYCLES - 1);
        end
      end
      RESYNC: begin
        if (cnt == '0) st_nx = SEARCH;
        else cnt_nx = cnt - 1'b1;
      end
      WAIT_DATA, DATA_OK, PARITY_OK: begin
        if (partial) begin
          st_nx  = RESYNC;
          cnt_nx = CW'(RST_CYCLES - 1);
        end else if (all_hit) begin
          if (st == WAIT_DATA)    st_nx = DATA_OK;
          else                    st_nx = PARITY_OK;
        end
      end
      default: st_nx = SEARCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= SEARCH;
      cnt <= '0;
    end else begin
      st  <= st_nx;
      cnt <= cnt_nx;
    end
  end

  assign resync_n_o     = (st != RESYNC);
  assign clk_stop_o     = (st == RESYNC);
  assign data_valid_o   = (st == DATA_OK) || (st == PARITY_OK);
  assign parity_valid_o = (st == PARITY_OK);

  logic [CW-1:0] low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      low_run <= '0;
    else if (!resync_n_o) begin
      if (low_run != CW'(RST_CYCLES)) low_run <= low_run + 1'b1;
    end else                         low_run <= '0;
  end

  a_r6_low_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resync_n_o) |-> (low_run == CW'(RST_CYCLES)));

  a_r6_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (low_run == CW'(RST_CYCLES)) |-> resync_n_o);

  a_r8_partial_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (resync_n_o && partial) |=> (!resync_n_o && !data_valid_o));

  a_r3_data_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_valid_o) |-> $past(all_hit));

  a_r10_parity_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    parity_valid_o |-> data_valid_o);

  a_r10_quiet_in_resync: assert property (@(posedge clk) disable iff (!rst_n)
    !resync_n_o |-> (!data_valid_o && clk_stop_o));

endmodule

// File: tb/trib_align_ctrl_tb.sv
module trib_align_ctrl_tb;
  localparam int unsigned NT = 4;
  localparam int unsigned RC = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NT-1:0] fp = '0;
  logic          resync_n, clk_stop, dval, pval;

  always #4 clk = ~clk;

  trib_align_ctrl #(.N_TRIB(NT), .RST_CYCLES(RC)) u_dut (
    .clk(clk), .rst_n(rst_n), .fp_i(fp),
    .resync_n_o(resync_n), .clk_stop_o(clk_stop),
    .data_valid_o(dval), .parity_valid_o(pval)
  );

  typedef struct { logic [3:0] exp; string tag; } item_t;
  item_t q[$];

  int checks = 0, fails = 0;
  int mst = 0;
  int mcnt = 0;
  bit done = 1'b0;

  task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {resync_n,stop,dv,pv} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(input logic [NT-1:0] v, input string tag);
    item_t it;
    bit all1, any1;
    @(negedge clk);
    fp = v;
    all1 = (v == '1);
    any1 = (v != '0);
    case (mst)
      0: if (all1) mst = 2; else if (any1) begin mst = 1; mcnt = RC - 1; end
      1: if (mcnt == 0) mst = 0; else mcnt--;
      default: if (any1 && !all1) begin mst = 1; mcnt = RC - 1; end
               else if (all1) mst = (mst == 2) ? 3 : 4;
    endcase
    it.exp = {mst != 1, mst == 1, mst >= 3, mst == 4};
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step('0, tag);
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      chk({resync_n, clk_stop, dval, pval}, it.exp, it.tag);
    end
  end

  initial begin
    #4;
    chk({resync_n, clk_stop, dval, pval}, 4'b1000, "R1 in reset");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 chk({resync_n, clk_stop, dval, pval}, 4'b1000, "R1 after release");
    idle(4, "R1 idle search");
    step('1, "R2 coincident from search");
    idle(5, "R2 waiting");
    step('1, "R3 data valid");
    idle(5, "R3 holding");
    step('1, "R4 parity valid");
    idle(5, "R4 holding");
    step('1, "R4 stays valid");
    idle(3, "R4 holding");
    step(4'b0010, "R8 partial in parity state");
    idle(4, "R6 reset window");
    step('1, "R7 coincident ignored");
    step(4'b0100, "R7 partial ignored");
    idle(RC, "R6 reset end");
    step('1, "R9 first coincident after reset");
    idle(4, "R9 no early data");
    step('1, "R9 data after second");
    step(4'b1000, "R8 partial in data state");
    idle(RC + 2, "R6 window");
    step(4'b0111, "R5 partial in search");
    idle(RC + 2, "R6 window");
    step('1, "R2 coincident");
    step(4'b0001, "R8 partial in wait state");
    idle(RC + 2, "R6 window");
    step('1, "R2 again");
    step('1, "R3 back to back");
    idle(3, "R3 end");
    @(negedge clk);
    fp = '0;
    repeat (2) @(posedge clk);
    #3 done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule